// File: doc/BRIEF.md
# Truncated-Modulus Binary Counter

This block is an up-counter whose number of states, the modulus, is a parameter that may be any value from 2 upward. The register width is derived from the modulus as the fewest bits that can hold that many states. When the modulus is a power of two, the counter wraps by plain binary overflow. Otherwise it returns to zero early, by watching only those bit positions that are 1 in the binary form of the modulus. It does not compare the count against a bound.

The bit-to-bit carry that would ripple through a chain of toggling stages is modelled as a chain of clock enables inside one clock domain. The recycle is detected one step ahead: when the count is at its last legal value and enable is high, the next value is decoded and zero is loaded in its place. The modulus value therefore never appears on the output. A terminal-count flag marks the last enabled step. The most significant count bit is also brought out as a divided clock whose period is one full counting cycle.

Top module: `modclr_counter`

## Requirements
- R1: The count register is W bits wide, where W is the smallest value with 2^W >= MODULUS (MODULUS=60 gives 6, 16 gives 4, 10 gives 4).
- R2: For a modulus that is not a power of two, each enabled clock edge advances the count by one from 0 up to MODULUS-1, and the edge after MODULUS-1 loads 0.
- R3: For a power-of-two modulus, the count passes through all 2^W values and wraps from all ones to 0 with no recycle logic.
- R4: The count output never shows a value at or above MODULUS during normal counting.
- R5: tc_o is high exactly when en_i is high and count_o equals MODULUS-1, and is low at every other time.
- R6: While en_i is low, count_o holds its value, also when it sits at MODULUS-1, and tc_o stays low.
- R7: Driving rst_ni low clears count_o to 0 at once, without waiting for a clock edge and whatever the level of en_i.
- R8: div_o equals the most significant count bit, so with en_i held high it rises once every MODULUS clock cycles.
- R9: After reset, count_o is 0 and tc_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| count_o | output | W | Current count |
| tc_o | output | 1 | Last enabled step of the counting cycle |
| div_o | output | 1 | Divided clock (most significant count bit) |

## Verification
The recycle to zero and the enable can act in the same cycle. The last legal value is the only state where tc_o depends on en_i, and the only state where the next load is zero and not an increment. The bench brings the counter to MODULUS-1 and then drops en_i for several edges. It checks that the count stays put and tc_o stays low. It then raises en_i again and checks that tc_o rises at once and that the following edge loads zero. A second case asserts the asynchronous reset while en_i is high at the last value, and checks that the output is zero before any further edge.

// File: rtl/modclr_pkg.sv
package modclr_pkg;

  // Fewest bits able to hold x distinct states.
  function automatic int cnt_width(int x);
    int w;
    w = 1;
    for (int i = 1; i < 31; i++) begin
      if ((1 << w) < x) w = w + 1;
    end
    return w;
  endfunction

  function automatic bit is_pow2(int x);
    return (x & (x - 1)) == 0;
  endfunction

  // True when every bit selected by mask is set in value.
  function automatic logic mask_hit(logic [31:0] value, logic [31:0] mask);
    return (value & mask) == mask;
  endfunction

endpackage

// File: rtl/modclr_stage.sv
module modclr_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (tgl_i) q_o <= ~q_o;
  end

endmodule

// File: rtl/modclr_recycle.sv
module modclr_recycle #(
  parameter int MODULUS = 60,
  parameter int WIDTH   = modclr_pkg::cnt_width(MODULUS)
) (
  input  logic [WIDTH-1:0] nxt_i,
  input  logic             step_i,
  output logic             clr_o,
  output logic             tc_o
);
  import modclr_pkg::*;

  localparam logic [31:0] MASK = 32'(MODULUS);

  generate
    if (is_pow2(MODULUS)) begin : g_natural
      // Overflow returns to zero by itself; last step is when next is zero.
      assign clr_o = 1'b0;
      assign tc_o  = step_i && (nxt_i == '0);
    end else begin : g_decode
      // Partial decode of the ones of MODULUS in the would-be next value.
      assign clr_o = step_i && mask_hit(32'(nxt_i), MASK);
      assign tc_o  = clr_o;
    end
  endgenerate

endmodule

// File: rtl/modclr_counter.sv
module modclr_counter #(
  parameter int MODULUS = 60,
  localparam int WIDTH  = modclr_pkg::cnt_width(MODULUS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o,
  output logic             div_o
);

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] chain;   // per-stage toggle enable
  logic [WIDTH-1:0] nxt;     // value the stages would take without recycle
  logic             wrap_clr;

  assign chain[0] = en_i;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      modclr_stage u_stage (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tgl_i (chain[i]),
        .clr_i (wrap_clr),
        .q_o   (q[i])
      );
      assign nxt[i] = q[i] ^ chain[i];
      if (i < WIDTH - 1) begin : g_link
        assign chain[i+1] = chain[i] & q[i];
      end
    end
  endgenerate

  modclr_recycle #(
    .MODULUS(MODULUS),
    .WIDTH  (WIDTH)
  ) u_recycle (
    .nxt_i (nxt),
    .step_i(en_i),
    .clr_o (wrap_clr),
    .tc_o  (tc_o)
  );

  assign count_o = q;
  assign div_o   = q[WIDTH-1];

endmodule

// File: rtl/modclr_counter_chk.sv
module modclr_counter_chk #(
  parameter int MODULUS = 60,
  parameter int WIDTH   = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [WIDTH-1:0] count_o,
  input logic             tc_o,
  input logic             div_o,
  input logic             wrap_clr
);

  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] HALF = WIDTH'(1) << (WIDTH - 1);

  // R4
  count_below_mod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count_o) < MODULUS);

  // R2
  tc_recycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> count_o == '0);

  // R2
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tc_o) |=> count_o == $past(count_o) + WIDTH'(1));

  // R2
  decode_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_clr |=> count_o == '0);

  // R5
  tc_at_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (en_i && count_o == LAST));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(count_o));

  // R8
  div_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_o) |-> count_o == HALF);

endmodule

bind modclr_counter modclr_counter_chk #(
  .MODULUS(MODULUS),
  .WIDTH  (WIDTH)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .count_o (count_o),
  .tc_o    (tc_o),
  .div_o   (div_o),
  .wrap_clr(wrap_clr)
);

// File: tb/modclr_counter_tb.sv
module modclr_counter_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;

  logic [5:0] cnt60;
  logic [3:0] cnt16, cnt10;
  logic tc60, tc16, tc10, div60, div16, div10;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  int e60 = 0, e16 = 0, e10 = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modclr_counter #(.MODULUS(60)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .count_o(cnt60), .tc_o(tc60), .div_o(div60));

  modclr_counter #(.MODULUS(16)) u_dut16 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .count_o(cnt16), .tc_o(tc16), .div_o(div16));

  modclr_counter #(.MODULUS(10)) u_dut10 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .count_o(cnt10), .tc_o(tc10), .div_o(div10));

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare all outputs against the models (inputs are stable here).
  task automatic compare_all();
    check("R2 count mod60", int'(cnt60), e60);
    check("R3 count mod16", int'(cnt16), e16);
    check("R2 count mod10", int'(cnt10), e10);
    check("R4 below mod60", int'(cnt60 < 6'd60), 1);
    check("R5 tc mod60", int'(tc60), int'(en && e60 == 59));
    check("R5 tc mod16", int'(tc16), int'(en && e16 == 15));
    check("R5 tc mod10", int'(tc10), int'(en && e10 == 9));
    check("R8 div mod60", int'(div60), e60 / 32);
  endtask

  // One clock edge, models advanced, outputs sampled 1 time unit later.
  task automatic tick();
    @(posedge clk);
    cyc++;
    if (en && rst_n) begin
      e60 = (e60 + 1) % 60;
      e16 = (e16 + 1) % 16;
      e10 = (e10 + 1) % 10;
    end
    #1;
    compare_all();
  endtask

  task automatic t_reset();
    #1;
    // R9
    check("R9 reset count", int'(cnt60), 0);
    check("R9 reset tc", int'(tc60), 0);
    check("R9 reset count16", int'(cnt16), 0);
    // R1
    check("R1 width mod60", $bits(cnt60), 6);
    check("R1 width mod16", $bits(u_dut16.count_o), 4);
    check("R1 width mod10", $bits(u_dut10.count_o), 4);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
  endtask

  // Two full cycles of the largest modulus: covers 59->0, 15->0, 9->0.
  task automatic t_count();
    en = 1'b1;
    for (int k = 0; k < 125; k++) tick();
  endtask

  task automatic t_hold_random();
    for (int k = 0; k < 40; k++) begin
      en = (k % 3) != 0;
      tick();
    end
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R6 hold", int'(cnt60), e60);
    end
  endtask

  task automatic run_to_last();
    en = 1'b1;
    while (e60 != 58) tick();
    tick();
  endtask

  // Enable drop exactly at MODULUS-1 overlaps with the recycle.
  task automatic t_overlap();
    run_to_last();
    en = 1'b0;
    #1;
    check("R6 tc low at last when disabled", int'(tc60), 0);
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R6 held at last", int'(cnt60), 59);
    end
    en = 1'b1;
    #1;
    check("R5 tc at last", int'(tc60), 1);
    tick();
    check("R2 recycle after resume", int'(cnt60), 0);
  endtask

  task automatic t_async_reset();
    run_to_last();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    // R7
    check("R7 async clear mod60", int'(cnt60), 0);
    check("R7 async clear mod16", int'(cnt16), 0);
    check("R7 async clear mod10", int'(cnt10), 0);
    e60 = 0; e16 = 0; e10 = 0;
    @(negedge clk);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_divide();
    int last60 = -1, last16 = -1;
    int gap60 = 0, gap16 = 0;
    logic p60, p16;
    en = 1'b1;
    p60 = div60; p16 = div16;
    for (int k = 0; k < 200; k++) begin
      tick();
      if (div60 && !p60) begin
        if (last60 >= 0) gap60 = cyc - last60;
        last60 = cyc;
      end
      if (div16 && !p16) begin
        if (last16 >= 0) gap16 = cyc - last16;
        last16 = cyc;
      end
      p60 = div60; p16 = div16;
    end
    check("R8 div period mod60", gap60, 60);
    check("R8 div period mod16", gap16, 16);
  endtask

  initial begin
    t_reset();
    t_count();
    t_hold_random();
    t_overlap();
    t_async_reset();
    t_divide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule